// File: doc/BRIEF.md
# Framed SPI Master with Sync Pulse

This block is a serial-peripheral master whose serial clock runs without pause, derived from the system clock by a programmable half-period count. Each word goes out inside a frame. The frame is marked by a synchronization pulse on a select line, and that pulse stays active for one word time. A host starts a frame by pulsing a write strobe with a 16-bit word. The word leaves on the serial data output, most significant bit first. At the same time a word is collected from the serial data input, and it is handed back with a one-cycle done pulse.

Three static controls set the waveform. One sets the idle level of the serial clock. One sets the active level of the sync line. One chooses whether the sync pulse leads the first data bit by one clock period or starts on the same edge as that bit. A word written while a frame is running waits in a single holding slot and goes out at the next frame boundary.

Top module: `fspi_master`

## Requirements
- R1: SCK changes level every `max(cfg_half,1)` system clock cycles, without pause, whether or not a frame is active. With `cfg_half` = 0 the divider behaves as with 1.
- R2: The transmit edge is the SCK edge that returns to the idle level (`cfg_sck_idle_hi`); the sample edge is the one that leaves it. `sdo` and the sync line change only on transmit edges.
- R3: After a write strobe into an empty slot with no frame active, the sync line goes active on the first transmit edge after the write cycle, at most 2·max(cfg_half,1) cycles later.
- R4: The sync line is high when active if `cfg_sync_act_hi` = 1 and low when active if it is 0; otherwise it sits at the opposite level.
- R5: The sync line stays active for exactly 16 SCK periods, measured between transmit edges.
- R6: With `cfg_sync_lead` = 1, bit 15 appears on `sdo` one SCK period after the sync line goes active. With 0, bit 15 appears on the same transmit edge. The control is taken at frame start.
- R7: `sdo` carries the word's bits 15 down to 0, one per SCK period, and is 0 outside the data bits.
- R8: `sdi` is sampled on the 16 sample edges of the data bits, the first sample landing in bit 15. After the 16th sample, `rx_word` holds the sampled word and `rx_done` is high for exactly one system cycle.
- R9: A word written while a frame is active is held and starts at the next frame boundary. In lead mode the sync line goes active again exactly one SCK period after it went inactive. Both words are received in order.
- R10: While `rst_n` is low (synchronous), SCK sits at its idle level, the sync line is inactive, `sdo` and `rx_done` are 0, and any held word is discarded, so no frame follows the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_half | input | DIV_W | SCK half period in system cycles (0 behaves as 1) |
| cfg_sck_idle_hi | input | 1 | SCK idle level |
| cfg_sync_act_hi | input | 1 | Sync line active level |
| cfg_sync_lead | input | 1 | 1: sync leads data by one SCK period; 0: sync starts with bit 15 |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | WORD_W | Word to transmit |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sync_o | output | 1 | Frame sync line |
| rx_word | output | WORD_W | Last received word |
| rx_done | output | 1 | One-cycle pulse when rx_word updates |

## Verification
The bench sweeps every combination of half period 1 to 3, both clock idle levels, both sync levels and both sync placements. Each combination gets two data words, and each word is looped back from `sdo` to `sdi` either straight or inverted, so a receiver that shifts the wrong way or samples on the wrong edge is told apart from one that only echoes the transmit register. A walking-one sweep isolates each bit position. Back-to-back writes in both sync placements separate a correct held-word handoff from a dropped or early frame. A write followed at once by reset shows that the held word is discarded.

// File: rtl/fspi_pkg.sv
package fspi_pkg;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_LEAD = 2'd1,
      FR_DATA = 2'd2
   } fr_state_t;

endpackage

// File: rtl/fspi_clkgen.sv
module fspi_clkgen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half,
   output logic             phase,
   output logic             tx_tick,
   output logic             smp_tick
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim_m1;
   logic             tick;

   assign lim_m1   = (half == '0) ? '0 : half - ONE;
   assign tick     = (cnt >= lim_m1);
   assign tx_tick  = tick & phase;
   assign smp_tick = tick & ~phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (tick) begin
         cnt   <= '0;
         phase <= ~phase;
      end else begin
         cnt   <= cnt + ONE;
      end
   end

endmodule

// File: rtl/fspi_holdreg.sv
module fspi_holdreg #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              take,
   output logic              valid,
   output logic [WORD_W-1:0] data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         if (take)
            valid <= 1'b0;
         if (wr_en) begin
            valid <= 1'b1;
            data  <= wr_data;
         end
      end
   end

   // R9
   take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> valid);

   // R9
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !take) |=> valid);

endmodule

// File: rtl/fspi_engine.sv
module fspi_engine
   import fspi_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_tick,
   input  logic              smp_tick,
   input  logic              lead_cfg,
   input  logic              pend_valid,
   input  logic [WORD_W-1:0] pend_data,
   input  logic              sdi,
   output logic              take,
   output logic              sdo,
   output logic              sync_act,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_done
);

   localparam int             CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] C_WORD = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(WORD_W - 1);

   fr_state_t         st;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;
   logic [CNT_W-1:0]  bits_left;
   logic [CNT_W-1:0]  smp_cnt;
   logic [CNT_W-1:0]  sync_left;
   logic              frame_end;

   assign frame_end = (st == FR_DATA) && (bits_left == C_ONE);
   assign take      = tx_tick && pend_valid && ((st == FR_IDLE) || frame_end);
   assign sdo       = (st == FR_DATA) ? tx_sh[WORD_W-1] : 1'b0;
   assign sync_act  = (sync_left != '0);

   // transmit side: advances on transmit edges only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= FR_IDLE;
         tx_sh     <= '0;
         bits_left <= '0;
         sync_left <= '0;
      end else if (tx_tick) begin
         if (take) begin
            tx_sh     <= pend_data;
            bits_left <= C_WORD;
            sync_left <= C_WORD;
            st        <= lead_cfg ? FR_LEAD : FR_DATA;
         end else begin
            if (sync_left != '0)
               sync_left <= sync_left - C_ONE;
            case (st)
               FR_LEAD: st <= FR_DATA;
               FR_DATA: begin
                  if (frame_end) begin
                     st <= FR_IDLE;
                  end else begin
                     tx_sh     <= {tx_sh[WORD_W-2:0], 1'b0};
                     bits_left <= bits_left - C_ONE;
                  end
               end
               default: st <= FR_IDLE;
            endcase
         end
      end
   end

   // receive side: advances on sample edges of data bits
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_sh   <= '0;
         rx_word <= '0;
         rx_done <= 1'b0;
         smp_cnt <= '0;
      end else begin
         rx_done <= 1'b0;
         if (smp_tick && (st == FR_DATA)) begin
            if (smp_cnt == C_LAST) begin
               rx_word <= {rx_sh[WORD_W-2:0], sdi};
               rx_done <= 1'b1;
               smp_cnt <= '0;
            end else begin
               rx_sh   <= {rx_sh[WORD_W-2:0], sdi};
               smp_cnt <= smp_cnt + C_ONE;
            end
         end
      end
   end

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

endmodule

// File: rtl/fspi_master.sv
module fspi_master #(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  cfg_half,
   input  logic              cfg_sck_idle_hi,
   input  logic              cfg_sync_act_hi,
   input  logic              cfg_sync_lead,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              sdi,
   output logic              sck,
   output logic              sdo,
   output logic              sync_o,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_done
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("fspi_master: WORD_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("fspi_master: DIV_W must be at least 1");
      end
   endgenerate

   logic              phase;
   logic              tx_tick;
   logic              smp_tick;
   logic              take;
   logic              pend_valid;
   logic [WORD_W-1:0] pend_data;
   logic              sync_act;

   fspi_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .half     (cfg_half),
      .phase    (phase),
      .tx_tick  (tx_tick),
      .smp_tick (smp_tick)
   );

   fspi_holdreg #(.WORD_W(WORD_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .take    (take),
      .valid   (pend_valid),
      .data    (pend_data)
   );

   fspi_engine #(.WORD_W(WORD_W)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_tick    (tx_tick),
      .smp_tick   (smp_tick),
      .lead_cfg   (cfg_sync_lead),
      .pend_valid (pend_valid),
      .pend_data  (pend_data),
      .sdi        (sdi),
      .take       (take),
      .sdo        (sdo),
      .sync_act   (sync_act),
      .rx_word    (rx_word),
      .rx_done    (rx_done)
   );

   assign sck    = phase ^ cfg_sck_idle_hi;
   assign sync_o = cfg_sync_act_hi ? sync_act : ~sync_act;

   // R2
   sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo != $past(sdo)) |-> $fell(phase));

   // R2
   sync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_act != $past(sync_act)) |-> $fell(phase));

endmodule

// File: tb/fspi_master_test.sv
`timescale 1ns/1ps
module fspi_master_test;

   localparam int W  = 16;
   localparam int DW = 8;
   localparam int WD = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] half = 8'd1;
   logic          cpol = 1'b0;
   logic          spol = 1'b1;
   logic          lead = 1'b0;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic          inv = 1'b0;
   logic          sdi;
   logic          sck, sdo, sync_o, rx_done;
   logic [W-1:0]  rx_word;

   always #10 clk = ~clk;

   assign sdi = sdo ^ inv;

   fspi_master #(.WORD_W(W), .DIV_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_half(half),
      .cfg_sck_idle_hi(cpol), .cfg_sync_act_hi(spol), .cfg_sync_lead(lead),
      .wr_en(wr_en), .wr_data(wr_data), .sdi(sdi),
      .sck(sck), .sdo(sdo), .sync_o(sync_o),
      .rx_word(rx_word), .rx_done(rx_done)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WD) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles, expected < %0d", cyc, WD);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   // ---------------- waveform monitor ----------------
   logic         mon_rst = 1'b0;
   logic         prev_sck, prev_act, act;
   logic [W-1:0] cap_word, cap_last;
   int gap, gap_err, len, last_len, cap_idx;
   int rise_cnt, fall_cnt, cap_cnt, rise_cyc, fall_cyc, rx_n;
   bit skip_gap, cap_on;
   logic [W-1:0] rx_q [0:63];

   assign act = (sync_o == spol);

   initial begin
      gap = 0; gap_err = 0; len = 0; last_len = 0; cap_idx = 0;
      rise_cnt = 0; fall_cnt = 0; cap_cnt = 0; rise_cyc = 0; fall_cyc = 0;
      rx_n = 0; skip_gap = 1; cap_on = 0; cap_word = '0; cap_last = '0;
      prev_sck = 1'b0; prev_act = 1'b0;
   end

   always @(negedge clk) begin
      if (!rst_n || mon_rst) begin
         prev_sck = sck;
         prev_act = act;
         gap      = 0;
         skip_gap = 1;
         cap_on   = 0;
      end else begin
         gap = gap + 1;
         if (sck != prev_sck) begin
            if (!skip_gap && gap != ((half == 0) ? 1 : int'(half)))
               gap_err = gap_err + 1;
            skip_gap = 0;
            gap = 0;
            if (sck == cpol) begin
               if (act && !prev_act) begin
                  rise_cnt = rise_cnt + 1;
                  rise_cyc = cyc;
                  len = 0;
                  cap_on = 1;
                  cap_idx = 0;
                  cap_word = '0;
               end else if (prev_act) begin
                  len = len + 1;
                  if (!act) begin
                     last_len = len;
                     fall_cyc = cyc;
                     fall_cnt = fall_cnt + 1;
                  end
               end
               prev_act = act;
            end else if (cap_on) begin
               automatic int pos = cap_idx - (lead ? 1 : 0);
               if (pos >= 0 && pos < W)
                  cap_word[W-1-pos] = sdo;
               if (pos == W-1) begin
                  cap_on = 0;
                  cap_last = cap_word;
                  cap_cnt = cap_cnt + 1;
               end
               cap_idx = cap_idx + 1;
            end
            prev_sck = sck;
         end
         if (rx_done) begin
            rx_q[rx_n % 64] = rx_word;
            rx_n = rx_n + 1;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: actual %0h expected %0h", req, a, e);
      end
   endtask

   int wr_cyc;

   task automatic write_word(input logic [W-1:0] w);
      tick();
      wr_en   = 1'b1;
      wr_data = w;
      wr_cyc  = cyc + 1;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic set_cfg(input int h, input bit cp, input bit sp, input bit ld);
      tick();
      half = DW'(h);
      cpol = cp;
      spol = sp;
      lead = ld;
      mon_rst = 1'b1;
      tick();
      tick();
      mon_rst = 1'b0;
   endtask

   function automatic int hl();
      return (half == 0) ? 1 : int'(half);
   endfunction

   task automatic idle_settle();
      repeat (4 * hl() + 2) tick();
   endtask

   // one isolated frame with all per-frame checks
   task automatic run_frame(input logic [W-1:0] w, input bit iv);
      int r0, f0, c0, x0, g0;
      logic [W-1:0] exp_rx;
      inv = iv;
      r0 = rise_cnt; f0 = fall_cnt; c0 = cap_cnt; x0 = rx_n; g0 = gap_err;
      exp_rx = w ^ {W{iv}};
      // R4 idle level before the frame
      chk(sync_o == ~spol, "R4 idle sync level", sync_o, ~spol);
      write_word(w);
      while (!(fall_cnt > f0 && cap_cnt > c0 && rx_n > x0)) tick();
      // R3 rise latency in system cycles
      chk((rise_cyc - wr_cyc) >= 1 && (rise_cyc - wr_cyc) <= 2 * hl(),
          "R3 sync rise latency", rise_cyc - wr_cyc, 2 * hl());
      // R5 sync length in SCK periods
      chk(last_len == W, "R5 sync length", last_len, W);
      // R6 R7 bit placement and order on sdo
      chk(cap_last == w, "R6 R7 sdo word", cap_last, w);
      // R8 received word
      chk(rx_q[(rx_n - 1) % 64] == exp_rx && rx_n == x0 + 1, "R8 rx word", rx_q[(rx_n - 1) % 64], exp_rx);
      // R1 SCK half period
      chk(gap_err == g0, "R1 sck half period errors", gap_err - g0, 0);
      idle_settle();
      // R1 clock keeps running while idle
      chk(gap_err == g0 && rise_cnt == r0 + 1, "R1 idle sck / single frame", rise_cnt - r0, 1);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      // R10 reset state
      repeat (3) tick();
      chk(sck == cpol, "R10 sck idle in reset", sck, cpol);
      chk(sync_o == ~spol, "R10 sync inactive in reset", sync_o, ~spol);
      chk(sdo == 1'b0 && rx_done == 1'b0, "R10 sdo/rx_done in reset", {sdo, rx_done}, 0);
      rst_n = 1'b1;
      repeat (4) tick();

      // full configuration sweep
      for (int h = 1; h <= 3; h++)
         for (int cp = 0; cp < 2; cp++)
            for (int sp = 0; sp < 2; sp++)
               for (int ld = 0; ld < 2; ld++) begin
                  automatic logic [W-1:0] a = 16'hA5C3 ^ W'(h * 16'h1357) ^ W'(cp * 16'h0F0F) ^ W'(sp * 16'h8001) ^ W'(ld * 16'h3C00);
                  set_cfg(h, cp[0], sp[0], ld[0]);
                  idle_settle();
                  run_frame(a, 1'b0);
                  run_frame(~{a[7:0], a[15:8]}, 1'b1);
               end

      // walking one, divider 0 behaves as 1
      set_cfg(0, 1'b0, 1'b1, 1'b1);
      idle_settle();
      for (int i = 0; i < W; i++)
         run_frame(W'(1) << i, i[0]);

      // R9 back-to-back in lead mode
      set_cfg(2, 1'b1, 1'b0, 1'b1);
      idle_settle();
      begin
         int r0, x0;
         inv = 1'b0;
         r0 = rise_cnt; x0 = rx_n;
         write_word(16'h1234);
         while (rise_cnt == r0) tick();
         write_word(16'hFEDC);
         while (rise_cnt < r0 + 2) tick();
         chk(rise_cyc - fall_cyc == 2 * hl(), "R9 lead gap between frames", rise_cyc - fall_cyc, 2 * hl());
         while (rx_n < x0 + 2) tick();
         chk(rx_q[x0 % 64] == 16'h1234, "R9 first held-order word", rx_q[x0 % 64], 16'h1234);
         chk(rx_q[(x0 + 1) % 64] == 16'hFEDC, "R9 second held word", rx_q[(x0 + 1) % 64], 16'hFEDC);
         idle_settle();
         idle_settle();
      end

      // R9 back-to-back with sync on first bit
      set_cfg(1, 1'b0, 1'b1, 1'b0);
      idle_settle();
      begin
         int r0, x0;
         inv = 1'b1;
         r0 = rise_cnt; x0 = rx_n;
         write_word(16'h0F1E);
         while (rise_cnt == r0) tick();
         write_word(16'hC3A5);
         while (rx_n < x0 + 2) tick();
         chk(rx_q[x0 % 64] == ~16'h0F1E, "R9 no-lead first word", rx_q[x0 % 64], ~16'h0F1E);
         chk(rx_q[(x0 + 1) % 64] == ~16'hC3A5, "R9 no-lead second word", rx_q[(x0 + 1) % 64], ~16'hC3A5);
         chk(rise_cnt == r0 + 1, "R9 sync held across frames", rise_cnt - r0, 1);
         idle_settle();
         idle_settle();
      end

      // R10 reset discards a held word
      set_cfg(3, 1'b1, 1'b1, 1'b0);
      idle_settle();
      begin
         int r0, x0;
         r0 = rise_cnt; x0 = rx_n;
         write_word(16'h5AA5);
         rst_n = 1'b0;
         repeat (3) tick();
         chk(sck == cpol && sync_o == ~spol, "R10 reset mid-request outputs", {sck, sync_o}, {cpol, ~spol});
         rst_n = 1'b1;
         repeat (60) tick();
         chk(rise_cnt == r0 && rx_n == x0 && sync_o == ~spol, "R10 held word discarded", rx_n - x0, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule